// File: doc/BRIEF.md
# Static LCD Segment and Backplane Driver

This block turns a latched three-and-a-half digit decimal result into the drive waveforms for a direct-drive liquid crystal display. A free-running divider makes a slow square wave for the common backplane electrode. Each segment line carries either that same wave (segment dark) or its inverse (segment lit), so no segment ever sees an average DC voltage.

Three full BCD digits are decoded to seven segments each. The leading half digit can only show a "1" and has a single line that drives its b and c segments together. A separate line drives the minus sign from the polarity input. The display data is captured only at backplane transitions, so a segment never changes state in the middle of a half-period. A lamp-test input overrides everything and holds all lines at a static high level, which lights every segment and shows "-1888".

Top module: `lcd_static_driver`

## Requirements
- R1: After reset is released, the backplane stays low for exactly PRE_DIV*BP_DIV/2 clock cycles and then goes high. Its frequency is the clock divided by PRE_DIV*BP_DIV, which is 800 with the defaults PRE_DIV=4 and BP_DIV=200.
- R2: The backplane has a 50 percent duty cycle. Each high phase and each low phase lasts exactly PRE_DIV*BP_DIV/2 clock cycles.
- R3: Outside lamp test, every segment, half-digit and minus line equals the backplane level when it is dark and the inverse of the backplane when it is lit. All of these lines change on the same clock edge as the backplane.
- R4: Each full digit i occupies seg_o[7*i+6:7*i], with segment a in bit 0 up to segment g in bit 6. Digit i takes its BCD code from digits_i[4*i+3:4*i]. The lit patterns are: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R5: The BCD codes 10 to 15 leave their digit dark, with all seven segments unlit.
- R6: The half-digit line is lit only when over_i is 1. When over_i is 0 it is dark.
- R7: The minus line is lit exactly when neg_i is 1. This holds even when every digit reads zero.
- R8: Digits, over_i and neg_i are sampled only on the clock edge where the backplane toggles. A change between two toggles has no effect on any output until the next toggle.
- R9: While lamp_i is high, all segment, half-digit and minus lines are held at a constant 1 that does not follow the backplane. The lines reach this level one clock after lamp_i is seen high. One clock after lamp_i goes low, the lines return to the backplane-relative pattern.
- R10: While reset is asserted, the backplane and all segment, half-digit and minus lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits_i | input | NUM_DIGITS*4 | BCD codes, least significant digit in the low nibble |
| over_i | input | 1 | Thousands bit; lights the half digit as "1" |
| neg_i | input | 1 | Polarity; 1 lights the minus sign |
| lamp_i | input | 1 | Lamp test; forces all lines to a static lit level |
| seg_o | output | NUM_DIGITS*7 | Segment lines of the full digits, a..g per digit |
| half_o | output | 1 | Combined b/c line of the half digit |
| minus_o | output | 1 | Minus-sign segment line |
| bp_o | output | 1 | Backplane square wave |

## Verification
The bench builds the block with PRE_DIV=2 and BP_DIV=4. This gives a backplane half-period of four clocks, so many backplane periods fit in a short run. With that setting the exact toggle cycle after reset and the length of both half-periods can be counted clock by clock. Every decoded pattern is seen in both backplane polarities. Data changes placed between toggles can be shown to stay invisible until the next toggle, and entry into and exit from lamp test can be timed to the clock.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  typedef logic [6:0] seg7_t;

  // Seven-segment pattern, segment a in bit 0 through g in bit 6.
  // Codes outside 0..9 produce a dark digit.
  function automatic seg7_t bcd_to_seg7(input logic [3:0] code);
    seg7_t pat;
    case (code)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int PRE_DIV = 4,
  parameter int BP_DIV  = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic bp_o,
  output logic edge_o
);

  localparam int HALF_TICKS = BP_DIV / 2;
  localparam int PW = (PRE_DIV < 2) ? 1 : $clog2(PRE_DIV);
  localparam int HW = (HALF_TICKS < 2) ? 1 : $clog2(HALF_TICKS);
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_TICKS - 1);

  logic [PW-1:0] pre_cnt_q, pre_cnt_d;
  logic [HW-1:0] half_cnt_q, half_cnt_d;
  logic          bp_q, bp_d;
  logic          tick;
  logic          toggle;

  // Next-state logic: prescaler, then half-period counter, then backplane.
  always_comb begin
    tick      = (pre_cnt_q == PRE_LAST);
    toggle    = tick && (half_cnt_q == HALF_LAST);
    pre_cnt_d = tick ? '0 : pre_cnt_q + 1'b1;
    half_cnt_d = half_cnt_q;
    if (tick) begin
      half_cnt_d = toggle ? '0 : half_cnt_q + 1'b1;
    end
    bp_d = toggle ? ~bp_q : bp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q  <= '0;
      half_cnt_q <= '0;
      bp_q       <= 1'b0;
    end else begin
      pre_cnt_q <= pre_cnt_d;
      if (tick) begin
        half_cnt_q <= half_cnt_d;
      end
      if (toggle) begin
        bp_q <= bp_d;
      end
    end
  end

  assign bp_o   = bp_q;
  assign edge_o = toggle;

  // R1: the backplane moves only on a cycle announced by the toggle strobe
  assert_bp_moves_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q != $past(bp_q)) |-> $past(edge_o));

  // R2: toggle strobes never come back to back, so both phases have equal length
  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

  // R2: the half-period counter stays inside its range
  assert_half_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    half_cnt_q <= HALF_LAST);

endmodule

// File: rtl/lcd_seg_decoder.sv
module lcd_seg_decoder
  import lcd_drv_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS*4-1:0] digits_i,
  input  logic                    over_i,
  input  logic                    neg_i,
  output logic [NUM_DIGITS*7+1:0] lit_o
);

  localparam int SEG_W = NUM_DIGITS * 7;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign lit_o[g*7 +: 7] = bcd_to_seg7(digits_i[g*4 +: 4]);
  end

  // Half digit lit as "1" only for a set thousands bit; sign from polarity
  assign lit_o[SEG_W]     = over_i;
  assign lit_o[SEG_W + 1] = neg_i;

endmodule

// File: rtl/lcd_phase_driver.sv
module lcd_phase_driver #(
  parameter int LIT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             bp_i,
  input  logic             lamp_i,
  input  logic [LIT_W-1:0] lit_i,
  output logic [LIT_W-1:0] line_o
);

  logic [LIT_W-1:0] lit_q, lit_d;
  logic             lamp_q;

  // Capture display data only when the backplane is about to toggle
  always_comb begin
    lit_d = edge_i ? lit_i : lit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit_q  <= '0;
      lamp_q <= 1'b0;
    end else begin
      lamp_q <= lamp_i;
      if (edge_i) begin
        lit_q <= lit_d;
      end
    end
  end

  // Lit segments run opposite to the backplane, dark ones follow it.
  // Lamp test holds a static level.
  always_comb begin
    if (lamp_q) begin
      line_o = '1;
    end else begin
      line_o = lit_q ^ {LIT_W{bp_i}};
    end
  end

  // R8: captured data holds between backplane toggles
  assert_lit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(edge_i) |-> $stable(lit_q));

  // R3: outside lamp test, no line moves within a backplane half-period
  assert_lines_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(edge_i) && !lamp_q && !$past(lamp_q)) |-> $stable(line_o));

  // R9: during lamp test the lines do not follow the backplane
  assert_lamp_static_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_q && $past(lamp_q)) |-> $stable(line_o));

endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
  import lcd_drv_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int PRE_DIV    = 4,
  parameter int BP_DIV     = 200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_DIGITS*4-1:0] digits_i,
  input  logic                    over_i,
  input  logic                    neg_i,
  input  logic                    lamp_i,
  output logic [NUM_DIGITS*7-1:0] seg_o,
  output logic                    half_o,
  output logic                    minus_o,
  output logic                    bp_o
);

  localparam int SEG_W = NUM_DIGITS * 7;
  localparam int LIT_W = SEG_W + 2;

  logic             bp;
  logic             bp_edge;
  logic [LIT_W-1:0] lit;
  logic [LIT_W-1:0] lines;

  lcd_bp_divider #(
    .PRE_DIV (PRE_DIV),
    .BP_DIV  (BP_DIV)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .bp_o   (bp),
    .edge_o (bp_edge)
  );

  lcd_seg_decoder #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_dec (
    .digits_i (digits_i),
    .over_i   (over_i),
    .neg_i    (neg_i),
    .lit_o    (lit)
  );

  lcd_phase_driver #(
    .LIT_W (LIT_W)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .edge_i (bp_edge),
    .bp_i   (bp),
    .lamp_i (lamp_i),
    .lit_i  (lit),
    .line_o (lines)
  );

  assign seg_o   = lines[SEG_W-1:0];
  assign half_o  = lines[SEG_W];
  assign minus_o = lines[SEG_W+1];
  assign bp_o    = bp;

  // R7: outside lamp test the minus line differs from the backplane only if polarity was captured negative
  assert_minus_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(lamp_i) && (minus_o != bp_o)) |-> lit[SEG_W+1] || !$past(bp_edge) || $past(neg_i));

endmodule

// File: tb/tb_lcd_static_driver.sv
module tb_lcd_static_driver;

  localparam int ND = 3;
  localparam int LW = ND * 7 + 2;
  localparam int HALF = 4; // PRE_DIV*BP_DIV/2 with 2 and 4

  logic clk = 1'b0;
  logic rst_n;
  logic [ND*4-1:0] digits;
  logic over, neg, lamp;
  logic [ND*7-1:0] seg;
  logic half, minus, bp;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_static_driver #(.NUM_DIGITS(ND), .PRE_DIV(2), .BP_DIV(4)) dut (
    .clk(clk), .rst_n(rst_n), .digits_i(digits), .over_i(over), .neg_i(neg),
    .lamp_i(lamp), .seg_o(seg), .half_o(half), .minus_o(minus), .bp_o(bp)
  );

  // Patterns from R4/R5
  function automatic logic [6:0] pat(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B; 4'd3: return 7'h4F;
      4'd4: return 7'h66; 4'd5: return 7'h6D; 4'd6: return 7'h7D; 4'd7: return 7'h07;
      4'd8: return 7'h7F; 4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  // vector: [13]=neg [12]=over [11:8]=hundreds [7:4]=tens [3:0]=ones
  function automatic logic [LW-1:0] exp_lit(input logic [13:0] v);
    return {v[13], v[12], pat(v[11:8]), pat(v[7:4]), pat(v[3:0])};
  endfunction

  localparam logic [13:0] VEC [8] = '{
    14'h2000, // R7 minus on a zero reading
    14'h1999, // R6 half digit with 999
    14'h0123, // R4
    14'h2456, // R4 R7
    14'h0789, // R4
    14'h0ABF, // R5 invalid codes dark
    14'h3000, // R6 R7 -1000
    14'h0CD0  // R5
  };

  task automatic check(input logic [LW-1:0] el, input logic elamp, input string req);
    logic [LW-1:0] act, expv;
    act  = {minus, half, seg};
    expv = elamp ? {LW{1'b1}} : (el ^ {LW{bp}});
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_bit(input logic a, input logic e, input string req);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, a, e);
    end
  endtask

  task automatic wait_toggle();
    logic prev;
    prev = bp;
    do @(negedge clk); while (bp == prev);
  endtask

  task automatic apply(input logic [13:0] v);
    neg = v[13]; over = v[12]; digits = v[11:0];
  endtask

  initial begin
    rst_n = 1'b0; lamp = 1'b0; apply(14'h0000);
    repeat (3) @(negedge clk);
    // R10 reset state
    check_bit(bp, 1'b0, "R10 bp in reset");
    check({LW{1'b0}}, 1'b0, "R10 lines in reset");
    rst_n = 1'b1;
    // R1 first toggle after HALF clocks
    for (int i = 1; i <= HALF; i++) begin
      @(negedge clk);
      check_bit(bp, (i >= HALF), "R1 first backplane rise");
    end
    check(exp_lit(14'h0000), 1'b0, "R3 R4 zeros after first toggle");
    // R2 high and low lengths
    begin
      int n;
      n = 0;
      do begin @(negedge clk); n++; end while (bp == 1'b1);
      check_bit(n == HALF, 1'b1, "R2 high phase length");
      n = 0;
      do begin @(negedge clk); n++; end while (bp == 1'b0);
      check_bit(n == HALF, 1'b1, "R2 low phase length");
    end
    // Vector table: each pattern in both backplane phases
    for (int k = 0; k < 8; k++) begin
      apply(VEC[k]);
      wait_toggle();
      check(exp_lit(VEC[k]), 1'b0, "R3 R4 R5 R6 R7 vector phase A");
      wait_toggle();
      check(exp_lit(VEC[k]), 1'b0, "R3 R4 R5 R6 R7 vector phase B");
    end
    // R8: change between toggles is invisible until the next toggle
    apply(14'h0111);
    wait_toggle();
    check(exp_lit(14'h0111), 1'b0, "R8 baseline");
    apply(14'h3888);
    check(exp_lit(14'h0111), 1'b0, "R8 no effect same cycle");
    @(negedge clk);
    check(exp_lit(14'h0111), 1'b0, "R8 no effect mid period");
    @(negedge clk);
    check(exp_lit(14'h0111), 1'b0, "R8 no effect late period");
    wait_toggle();
    check(exp_lit(14'h3888), 1'b0, "R8 taken at toggle");
    // R9 lamp test
    apply(14'h0000);
    lamp = 1'b1;
    check(exp_lit(14'h3888), 1'b0, "R9 not yet in lamp test");
    @(negedge clk);
    check({LW{1'b1}}, 1'b1, "R9 lamp test entered");
    wait_toggle();
    check({LW{1'b1}}, 1'b1, "R9 lamp static across toggle");
    lamp = 1'b0;
    @(negedge clk);
    check(exp_lit(14'h0000), 1'b0, "R9 lamp test released");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule